// File: doc/BRIEF.md
# DMA Address Increment Generator

This block produces the per-element read and write addresses for one DMA transfer. Software-side configuration gives a data size shared by both sides, a separate step for the source and for the destination, the address of the **last** element on each side, and an element count. The generator works backward from each end address to the first element's address. It then presents one read address and one write address per element. A byte-lane strobe follows each address.

A start pulse captures the configuration. When the configuration is legal, the first element appears on the following cycle with `valid` high. Each `step` pulse taken while `valid` is high moves both sides to the next element. A step on the final element drops `valid` and raises `done`. Each side steps on its own, so data can be packed or spread across memory. A side with no increment, such as a peripheral FIFO register, keeps one fixed address for the whole transfer.

A configuration with a reserved code, a step smaller than the data size, or an end address that is misaligned for the data size raises `cfg_err` and issues no elements.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset `valid`, `done` and `cfg_err` are 0.
- R2: One cycle after a legal `start` with count N≥1, `valid` is 1. `rd_addr` equals src_end − (N−1)×src step and `wr_addr` equals dst_end − (N−1)×dst step. The step code is 00=1 byte, 01=2, 10=4 and 11=none.
- R3: Each `step` while `valid` is high advances `rd_addr` by the source step and `wr_addr` by the destination step. The two steps are applied independently, and the last element sits at the end address.
- R4: A side with step code 11 presents its end address for every element.
- R5: A `step` on the last element clears `valid` and sets `done` on the next cycle. `done` stays set until the next `start`.
- R6: The size code is 00=8 bits, 01=16 bits, 10=32 bits. The strobe is 1<<addr[1:0] for 8-bit data. For 16-bit data it is 4'b0011 when addr[1]=0 and 4'b1100 otherwise. For 32-bit data it is 4'b1111. Strobes are 0 while `valid` is low.
- R7: A step code other than 11 whose step is smaller than the data size raises `cfg_err`, and `valid` stays 0. A larger step, such as 8-bit data with a 4-byte step, is legal.
- R8: An end address with bit 0 set for 16-bit data, or with either of bits 1:0 set for 32-bit data, raises `cfg_err`, and `valid` stays 0.
- R9: Size code 11 raises `cfg_err`.
- R10: A legal `start` with count 0 sets `done` on the next cycle, and `valid` stays 0.
- R11: A `step` while `valid` is low has no effect on `valid`, `done`, `rd_addr` or `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration, begin transfer |
| size | input | 2 | Data size code |
| src_inc | input | 2 | Source step code |
| dst_inc | input | 2 | Destination step code |
| src_end | input | AW | Address of last source element |
| dst_end | input | AW | Address of last destination element |
| count | input | CW | Number of elements |
| step | input | 1 | Advance to next element |
| rd_addr | output | AW | Current source address |
| wr_addr | output | AW | Current destination address |
| rd_strb | output | 4 | Source byte lanes |
| wr_strb | output | 4 | Destination byte lanes |
| valid | output | 1 | Current element is live |
| done | output | 1 | All elements issued |
| cfg_err | output | 1 | Captured configuration is illegal |

## Verification
The bench walks transfers element by element. It checks the first addresses for the back-computation from the end pointers: a design that counts forward from the end pointer, or is off by one element, misses the start address. It mixes unequal source and destination steps with a fixed side, which exposes a design that shares one step between both sides or moves a fixed FIFO address. Further cases cover the size/step legality edge (equal is legal, one code smaller is not), misaligned end pointers, reserved size and a zero count, each of which a careless design would let issue elements. It also checks that a stray step after completion leaves `done` and the addresses untouched.

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    size,
  input  logic [1:0]    src_inc,
  input  logic [1:0]    dst_inc,
  input  logic [AW-1:0] src_end,
  input  logic [AW-1:0] dst_end,
  input  logic [CW-1:0] count,
  input  logic          step,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic [3:0]    rd_strb,
  output logic [3:0]    wr_strb,
  output logic          valid,
  output logic          done,
  output logic          cfg_err
);

  localparam logic [1:0] NONE = 2'b11;

  function automatic logic [AW-1:0] inc_bytes(input logic [1:0] c);
    case (c)
      2'b00:   return AW'(1);
      2'b01:   return AW'(2);
      2'b10:   return AW'(4);
      default: return '0;
    endcase
  endfunction

  function automatic logic [3:0] lanes(input logic [1:0] s, input logic [1:0] a);
    case (s)
      2'b00:   return 4'b0001 << a;
      2'b01:   return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  logic [1:0]    sz, si, di;
  logic [AW-1:0] sa, da;
  logic [CW-1:0] rem;

  wire inc_bad_s = (src_inc != NONE) && (src_inc < size);
  wire inc_bad_d = (dst_inc != NONE) && (dst_inc < size);
  wire mis_s = (size == 2'b01 && src_end[0]) || (size == 2'b10 && src_end[1:0] != 2'b00);
  wire mis_d = (size == 2'b01 && dst_end[0]) || (size == 2'b10 && dst_end[1:0] != 2'b00);
  wire bad   = (size == 2'b11) || inc_bad_s || inc_bad_d || mis_s || mis_d;

  wire [AW-1:0] span = AW'(count - 1'b1);
  wire [AW-1:0] soff = span * inc_bytes(src_inc);
  wire [AW-1:0] doff = span * inc_bytes(dst_inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sz <= '0; si <= '0; di <= '0;
      sa <= '0; da <= '0; rem <= '0;
      valid <= 1'b0; done <= 1'b0; cfg_err <= 1'b0;
    end else if (start) begin
      sz <= size; si <= src_inc; di <= dst_inc;
      cfg_err <= bad;
      rem <= count;
      if (bad || count == '0) begin
        valid <= 1'b0;
        done  <= !bad;
      end else begin
        valid <= 1'b1;
        done  <= 1'b0;
        sa <= src_end - soff;
        da <= dst_end - doff;
      end
    end else if (step && valid) begin
      if (rem == CW'(1)) begin
        valid <= 1'b0;
        done  <= 1'b1;
      end else begin
        sa  <= sa + inc_bytes(si);
        da  <= da + inc_bytes(di);
        rem <= rem - 1'b1;
      end
    end
  end

  assign rd_addr = sa;
  assign wr_addr = da;
  assign rd_strb = valid ? lanes(sz, sa[1:0]) : 4'b0000;
  assign wr_strb = valid ? lanes(sz, da[1:0]) : 4'b0000;

  // R5
  live_or_done_chk: assert property (@(posedge clk) disable iff (!rst_n) !(valid && done));
  // R7
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !valid);
  // R4
  fixed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && step && !start && si == NONE) |=> $stable(rd_addr));
  // R5
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && step && !start && rem == CW'(1)) |=> (done && !valid));
  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sz == 2'b00) |-> ($countones(rd_strb) == 1 && $countones(wr_strb) == 1));
  // R8
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sz == 2'b10) |-> (rd_addr[1:0] == 2'b00 && wr_addr[1:0] == 2'b00));
  // R11
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && step && !start) |=> ($stable(rd_addr) && $stable(wr_addr) && $stable(done) && !valid));

endmodule

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0, start = 0, step = 0;
  logic [1:0] size = 0, src_inc = 0, dst_inc = 0;
  logic [AW-1:0] src_end = 0, dst_end = 0;
  logic [CW-1:0] count = 0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [3:0] rd_strb, wr_strb;
  logic valid, done, cfg_err;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  dma_addr_gen #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size), .src_inc(src_inc),
    .dst_inc(dst_inc), .src_end(src_end), .dst_end(dst_end), .count(count),
    .step(step), .rd_addr(rd_addr), .wr_addr(wr_addr), .rd_strb(rd_strb),
    .wr_strb(wr_strb), .valid(valid), .done(done), .cfg_err(cfg_err));

  function automatic int incv(input logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : 0;
  endfunction

  function automatic logic [3:0] exp_strb(input logic [1:0] s, input logic [1:0] a);
    if (s == 2'b00) return 4'b0001 << a;
    if (s == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] s, input logic [1:0] si, input logic [1:0] di,
                          input logic [AW-1:0] se, input logic [AW-1:0] de, input int n);
    @(negedge clk);
    size = s; src_inc = si; dst_inc = di; src_end = se; dst_end = de; count = CW'(n);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_step();
    step = 1;
    @(negedge clk);
    step = 0;
  endtask

  task automatic run_xfer(input string tag, input logic [1:0] s, input logic [1:0] si,
                          input logic [1:0] di, input logic [AW-1:0] se,
                          input logic [AW-1:0] de, input int n);
    do_start(s, si, di, se, de, n);
    check({tag, " R2 valid"}, valid, 1);
    check({tag, " R7 no err"}, cfg_err, 0);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ea, eb;
      ea = se - AW'((n - 1 - k) * incv(si));
      eb = de - AW'((n - 1 - k) * incv(di));
      check({tag, (k == 0) ? " R2 rd" : " R3 rd"}, rd_addr, ea);
      check({tag, (k == 0) ? " R2 wr" : " R3 wr"}, wr_addr, eb);
      if (si == 2'b11) check({tag, " R4 fixed rd"}, rd_addr, se);
      if (di == 2'b11) check({tag, " R4 fixed wr"}, wr_addr, de);
      check({tag, " R6 rd strb"}, rd_strb, exp_strb(s, ea[1:0]));
      check({tag, " R6 wr strb"}, wr_strb, exp_strb(s, eb[1:0]));
      check({tag, " R5 not done"}, done, 0);
      pulse_step();
    end
    check({tag, " R5 valid low"}, valid, 0);
    check({tag, " R5 done"}, done, 1);
    check({tag, " R6 strb off"}, {rd_strb, wr_strb}, 0);
    @(negedge clk);
    check({tag, " R5 done held"}, done, 1);
  endtask

  task automatic t_reset();
    check("R1 valid", valid, 0);
    check("R1 done", done, 0);
    check("R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_fifo_to_mem();
    run_xfer("fifo8", 2'b00, 2'b11, 2'b00, 32'h4000_0010, 32'h2000_0107, 4);
  endtask

  task automatic t_spread();
    run_xfer("spread8", 2'b00, 2'b00, 2'b10, 32'h0000_0203, 32'h0000_0100, 3);
  endtask

  task automatic t_half();
    run_xfer("half", 2'b01, 2'b01, 2'b10, 32'h0000_0306, 32'h0000_0500, 5);
  endtask

  task automatic t_word();
    run_xfer("word", 2'b10, 2'b10, 2'b11, 32'h0000_1000, 32'h4000_2000, 3);
    run_xfer("single", 2'b10, 2'b10, 2'b10, 32'h0000_0040, 32'h0000_0080, 1);
  endtask

  task automatic t_errors();
    do_start(2'b10, 2'b01, 2'b10, 32'h100, 32'h200, 2);
    check("R7 inc<size err", cfg_err, 1);
    check("R7 inc<size no valid", valid, 0);
    do_start(2'b01, 2'b01, 2'b00, 32'h100, 32'h200, 2);
    check("R7 dst inc<size err", cfg_err, 1);
    do_start(2'b01, 2'b01, 2'b11, 32'h101, 32'h200, 2);
    check("R8 half misalign err", cfg_err, 1);
    check("R8 no valid", valid, 0);
    do_start(2'b10, 2'b10, 2'b10, 32'h100, 32'h202, 2);
    check("R8 word misalign err", cfg_err, 1);
    do_start(2'b11, 2'b11, 2'b11, 32'h100, 32'h200, 2);
    check("R9 reserved size err", cfg_err, 1);
    check("R9 no valid", valid, 0);
    do_start(2'b10, 2'b10, 2'b10, 32'h100, 32'h200, 2);
    check("R7 legal clears err", cfg_err, 0);
  endtask

  task automatic t_zero();
    do_start(2'b00, 2'b00, 2'b00, 32'h10, 32'h20, 0);
    check("R10 done", done, 1);
    check("R10 no valid", valid, 0);
  endtask

  task automatic t_idle_step();
    logic [AW-1:0] ra, wa;
    run_xfer("pre", 2'b00, 2'b00, 2'b00, 32'h33, 32'h44, 2);
    ra = rd_addr; wa = wr_addr;
    pulse_step();
    check("R11 valid", valid, 0);
    check("R11 done", done, 1);
    check("R11 rd", rd_addr, ra);
    check("R11 wr", wr_addr, wa);
  endtask

  initial begin
    #100000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fifo_to_mem();
    t_spread();
    t_half();
    t_word();
    t_errors();
    t_zero();
    t_idle_step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule